// File: doc/BRIEF.md
# RS-485 Multidrop Receive Filter and Direction Driver

This block sits after a UART deserializer on an RS-485 multidrop bus that uses 9-bit framing. The ninth received bit, which occupies the parity slot, marks a byte as a station address. In multidrop mode the block flags each such byte and raises an address-detect interrupt. When hardware address matching is on, it compares the address with a programmed station address and opens or closes the receive path by itself. Data bytes are forwarded to the receive store only while the receive path is open. A software-written receive-off bit can also close the path.

On the transmit side, the block drives a bus-direction output while the local transmitter is active. The output goes on one of two modem-control pins, chosen by a select bit. The unselected pin keeps its ordinary modem value, and a polarity bit can invert the direction level. All outputs are registered. The asynchronous reset is released through a synchronizer.

Top module: `rs485_mdrop_ctrl`

## Requirements
- R1: With `cfg_multidrop`=1, a strobed byte whose `rx_bit9`=1 is an address byte. The cycle after the strobe, `addr_irq` is 1 for one cycle, and if the byte is forwarded, `out_is_addr`=1.
- R2: With `cfg_multidrop`=0, `rx_bit9` is ignored. Every byte is handled as data, `addr_irq` stays 0 and `out_is_addr` stays 0.
- R3: A data byte (not an address byte) appears on `out_data` with `out_valid`=1 the cycle after its strobe, but only if `rx_off` was 0 in the strobe cycle. Otherwise `out_valid` stays 0.
- R4: `rx_off` is 0 after reset. A cycle with `rxoff_we`=1 loads `rxoff_val` into `rx_off` for the next cycle.
- R5: With `cfg_auto_addr`=1, an address byte equal to `cfg_station` clears `rx_off` and is itself forwarded with `out_is_addr`=1.
- R6: With `cfg_auto_addr`=1, an address byte that differs from `cfg_station` sets `rx_off` and is not forwarded. The interrupt of R1 is still raised.
- R7: With `cfg_auto_addr`=0 in multidrop mode, an address byte is forwarded only while `rx_off`=0, and the hardware leaves `rx_off` unchanged.
- R8: When an address byte under `cfg_auto_addr`=1 arrives in the same cycle as `rxoff_we`=1, the address-match result decides `rx_off`.
- R9: With `cfg_dir_en`=1 and `cfg_dir_sel`=0, `rts_pin` equals `tx_active` XOR `cfg_dir_inv`, one cycle later. `dtr_pin` follows `dtr_modem`, one cycle later.
- R10: With `cfg_dir_en`=1 and `cfg_dir_sel`=1, `dtr_pin` carries the direction level and `rts_pin` follows `rts_modem`, both one cycle later.
- R11: With `cfg_dir_en`=0, `rts_pin` and `dtr_pin` follow `rts_modem` and `dtr_modem` one cycle later, regardless of `tx_active`.
- R12: During and right after reset, `out_valid`, `out_is_addr`, `addr_irq`, `rx_off`, `out_data`, `rts_pin` and `dtr_pin` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | DATA_W | Received byte |
| rx_bit9 | input | 1 | Ninth (parity-slot) bit of the received frame |
| rx_valid | input | 1 | One-cycle strobe for a received frame |
| tx_active | input | 1 | Transmitter busy, from the first start bit to the last stop bit |
| cfg_multidrop | input | 1 | Treat the ninth bit as the address marker |
| cfg_auto_addr | input | 1 | Hardware station-address matching |
| cfg_station | input | DATA_W | Programmed station address |
| rxoff_we | input | 1 | Software write strobe for the receive-off bit |
| rxoff_val | input | 1 | Value written to the receive-off bit |
| cfg_dir_en | input | 1 | Enable automatic direction drive |
| cfg_dir_sel | input | 1 | Direction pin: 0 = RTS, 1 = DTR |
| cfg_dir_inv | input | 1 | Invert the direction level |
| rts_modem | input | 1 | Normal RTS modem-control value |
| dtr_modem | input | 1 | Normal DTR modem-control value |
| out_data | output | DATA_W | Forwarded byte |
| out_valid | output | 1 | Forwarded-byte strobe |
| out_is_addr | output | 1 | Forwarded byte is an address |
| addr_irq | output | 1 | Address-detect interrupt pulse |
| rx_off | output | 1 | Current receive-off state |
| rts_pin | output | 1 | RTS pin |
| dtr_pin | output | 1 | DTR pin |

## Verification
The bench builds the block with its default 8-bit data width and a two-stage reset synchronizer. At that width the station comparison can be driven at both ends of the address range, 0x00 and 0xFF, as well as with neighbours that differ in one bit. The two-pin default exercises both choices of the direction select, with the polarity bit both clear and set. A behavioural model compares every output on every clock. This includes the cycle in which a software write to the receive-off bit collides with a hardware address match.

// File: rtl/rs485_mdrop_pkg.sv
package rs485_mdrop_pkg;
  localparam int DIR_PINS = 2;

  typedef struct packed {
    logic en;
    logic sel;
    logic inv;
  } dir_cfg_t;
endpackage

// File: rtl/rs485_rst_sync.sv
module rs485_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rs485_addr_filter.sv
module rs485_addr_filter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_bit9,
  input  logic              rx_valid,
  input  logic              multidrop,
  input  logic              auto_addr,
  input  logic [DATA_W-1:0] station,
  input  logic              rxoff_we,
  input  logic              rxoff_val,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_is_addr,
  output logic              addr_irq,
  output logic              rx_off
);
  logic [DATA_W-1:0] data_q, data_d;
  logic              valid_q, valid_d;
  logic              isaddr_q, isaddr_d;
  logic              irq_q, irq_d;
  logic              off_q, off_d;
  logic              addr_byte, hw_match, hw_decide;

  always_comb begin
    addr_byte = multidrop & rx_bit9;
    hw_match  = (rx_data == station);
    hw_decide = rx_valid & addr_byte & auto_addr;

    valid_d = 1'b0;
    if (rx_valid) begin
      if (addr_byte && auto_addr) valid_d = hw_match;
      else                        valid_d = ~off_q;
    end
    isaddr_d = valid_d & addr_byte;
    irq_d    = rx_valid & addr_byte;
    data_d   = valid_d ? rx_data : data_q;

    off_d = off_q;
    if (hw_decide)     off_d = ~hw_match;
    else if (rxoff_we) off_d = rxoff_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      valid_q  <= 1'b0;
      isaddr_q <= 1'b0;
      irq_q    <= 1'b0;
      off_q    <= 1'b0;
    end else begin
      data_q   <= data_d;
      valid_q  <= valid_d;
      isaddr_q <= isaddr_d;
      irq_q    <= irq_d;
      off_q    <= off_d;
    end
  end

  assign out_data    = data_q;
  assign out_valid   = valid_q;
  assign out_is_addr = isaddr_q;
  assign addr_irq    = irq_q;
  assign rx_off      = off_q;
endmodule

// File: rtl/rs485_dir_drive.sv
module rs485_dir_drive
  import rs485_mdrop_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_active,
  input  dir_cfg_t            cfg,
  input  logic [DIR_PINS-1:0] modem,
  output logic [DIR_PINS-1:0] pins
);
  logic [DIR_PINS-1:0] pins_q, pins_d;
  logic                dir_level;

  assign dir_level = tx_active ^ cfg.inv;

  for (genvar i = 0; i < DIR_PINS; i++) begin : g_pin
    always_comb begin
      if (cfg.en && (cfg.sel == 1'(i))) pins_d[i] = dir_level;
      else                              pins_d[i] = modem[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= '0;
    else        pins_q <= pins_d;
  end

  assign pins = pins_q;
endmodule

// File: rtl/rs485_mdrop_ctrl.sv
module rs485_mdrop_ctrl
  import rs485_mdrop_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_bit9,
  input  logic              rx_valid,
  input  logic              tx_active,
  input  logic              cfg_multidrop,
  input  logic              cfg_auto_addr,
  input  logic [DATA_W-1:0] cfg_station,
  input  logic              rxoff_we,
  input  logic              rxoff_val,
  input  logic              cfg_dir_en,
  input  logic              cfg_dir_sel,
  input  logic              cfg_dir_inv,
  input  logic              rts_modem,
  input  logic              dtr_modem,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_is_addr,
  output logic              addr_irq,
  output logic              rx_off,
  output logic              rts_pin,
  output logic              dtr_pin
);
  logic                rst_sync_n;
  dir_cfg_t            dir_cfg;
  logic [DIR_PINS-1:0] modem_vec, pin_vec;

  rs485_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  rs485_addr_filter #(.DATA_W(DATA_W)) u_filt (
    .clk(clk), .rst_n(rst_sync_n),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_valid(rx_valid),
    .multidrop(cfg_multidrop), .auto_addr(cfg_auto_addr), .station(cfg_station),
    .rxoff_we(rxoff_we), .rxoff_val(rxoff_val),
    .out_data(out_data), .out_valid(out_valid), .out_is_addr(out_is_addr),
    .addr_irq(addr_irq), .rx_off(rx_off)
  );

  assign dir_cfg   = '{en: cfg_dir_en, sel: cfg_dir_sel, inv: cfg_dir_inv};
  assign modem_vec = {dtr_modem, rts_modem};

  rs485_dir_drive u_dir (
    .clk(clk), .rst_n(rst_sync_n), .tx_active(tx_active),
    .cfg(dir_cfg), .modem(modem_vec), .pins(pin_vec)
  );

  assign rts_pin = pin_vec[0];
  assign dtr_pin = pin_vec[1];
endmodule

// File: rtl/rs485_mdrop_ctrl_chk.sv
module rs485_mdrop_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_bit9,
  input logic              rx_valid,
  input logic              tx_active,
  input logic              cfg_multidrop,
  input logic              cfg_auto_addr,
  input logic [DATA_W-1:0] cfg_station,
  input logic              rxoff_we,
  input logic              cfg_dir_en,
  input logic              cfg_dir_sel,
  input logic              cfg_dir_inv,
  input logic              rts_modem,
  input logic              dtr_modem,
  input logic              out_valid,
  input logic              out_is_addr,
  input logic              addr_irq,
  input logic              rx_off,
  input logic              rts_pin,
  input logic              dtr_pin
);
  p_addr_irq_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_valid && cfg_multidrop && rx_bit9) |=> addr_irq);

  p_no_addr_flag_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cfg_multidrop) |=> (!addr_irq && !out_is_addr));

  p_blocked_data_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_valid && rx_off && !(cfg_multidrop && rx_bit9)) |=> !out_valid);

  p_match_opens_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_valid && cfg_multidrop && rx_bit9 && cfg_auto_addr && rx_data == cfg_station)
    |=> (!rx_off && out_valid && out_is_addr));

  p_mismatch_closes_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_valid && cfg_multidrop && rx_bit9 && cfg_auto_addr && rx_data != cfg_station)
    |=> (rx_off && !out_valid));

  p_off_held_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!rxoff_we && !(rx_valid && cfg_multidrop && rx_bit9 && cfg_auto_addr))
    |=> $stable(rx_off));

  p_rts_dir_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_dir_en && !cfg_dir_sel) |=>
      (rts_pin == $past(tx_active ^ cfg_dir_inv) && dtr_pin == $past(dtr_modem)));

  p_dtr_dir_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_dir_en && cfg_dir_sel) |=>
      (dtr_pin == $past(tx_active ^ cfg_dir_inv) && rts_pin == $past(rts_modem)));

  p_modem_pass_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cfg_dir_en) |=> (rts_pin == $past(rts_modem) && dtr_pin == $past(dtr_modem)));
endmodule

bind rs485_mdrop_ctrl rs485_mdrop_ctrl_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/rs485_mdrop_ctrl_bench.sv
module rs485_mdrop_ctrl_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] rx_data = '0;
  logic         rx_bit9 = 1'b0, rx_valid = 1'b0, tx_active = 1'b0;
  logic         cfg_multidrop = 1'b0, cfg_auto_addr = 1'b0;
  logic [W-1:0] cfg_station = '0;
  logic         rxoff_we = 1'b0, rxoff_val = 1'b0;
  logic         cfg_dir_en = 1'b0, cfg_dir_sel = 1'b0, cfg_dir_inv = 1'b0;
  logic         rts_modem = 1'b0, dtr_modem = 1'b0;
  logic [W-1:0] out_data;
  logic         out_valid, out_is_addr, addr_irq, rx_off, rts_pin, dtr_pin;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R12";
  bit    model_on = 1'b0;

  int m_data = 0, m_valid = 0, m_isaddr = 0, m_irq = 0, m_off = 0, m_rts = 0, m_dtr = 0;

  always #4 clk = ~clk;

  rs485_mdrop_ctrl #(.DATA_W(W)) u_rs485_mdrop_ctrl (.*);

  // Behavioural reference: evaluated from pre-edge inputs at every rising edge.
  always @(posedge clk) begin
    if (!model_on) begin
      m_data = 0; m_valid = 0; m_isaddr = 0; m_irq = 0; m_off = 0; m_rts = 0; m_dtr = 0;
    end else begin
      automatic bit is_addr = cfg_multidrop && rx_bit9;
      automatic bit fwd     = 1'b0;
      automatic bit hit     = (rx_data == cfg_station);
      automatic int dirlvl  = int'(tx_active ^ cfg_dir_inv);
      if (rx_valid) fwd = (is_addr && cfg_auto_addr) ? hit : (m_off == 0);
      m_valid  = fwd;
      m_isaddr = fwd && is_addr;
      m_irq    = rx_valid && is_addr;
      if (fwd) m_data = int'(rx_data);
      if (rx_valid && is_addr && cfg_auto_addr) m_off = hit ? 0 : 1;
      else if (rxoff_we)                       m_off = int'(rxoff_val);
      m_rts = (cfg_dir_en && !cfg_dir_sel) ? dirlvl : int'(rts_modem);
      m_dtr = (cfg_dir_en &&  cfg_dir_sel) ? dirlvl : int'(dtr_modem);
    end
  end

  task automatic cmp(string name, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", cur_req, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      cmp("out_valid", int'(out_valid), m_valid);
      cmp("out_is_addr", int'(out_is_addr), m_isaddr);
      cmp("addr_irq", int'(addr_irq), m_irq);
      cmp("rx_off", int'(rx_off), m_off);
      cmp("out_data", int'(out_data), m_data);
      cmp("rts_pin", int'(rts_pin), m_rts);
      cmp("dtr_pin", int'(dtr_pin), m_dtr);
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic rx(logic [W-1:0] d, logic b9);
    rx_data = d; rx_bit9 = b9; rx_valid = 1'b1;
    step();
    rx_valid = 1'b0; rx_bit9 = 1'b0;
    step();
  endtask

  task automatic sw_off(logic v);
    rxoff_we = 1'b1; rxoff_val = v;
    step();
    rxoff_we = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R12: reset state
    step(2);
    cur_req = "R12";
    cmp("rst out_valid", int'(out_valid), 0);
    cmp("rst rx_off", int'(rx_off), 0);
    cmp("rst addr_irq", int'(addr_irq), 0);
    cmp("rst pins", int'({rts_pin, dtr_pin}), 0);
    cmp("rst out_data", int'(out_data), 0);
    rst_n = 1'b1;
    step(4);
    model_on = 1'b1;
    step(1);

    cur_req = "R3";
    rx(8'h31, 1'b0); rx(8'hC4, 1'b0); rx(8'h00, 1'b0);

    cur_req = "R2";
    rx(8'h77, 1'b1); rx(8'hFF, 1'b1);

    cur_req = "R4";
    sw_off(1'b1); step();
    cur_req = "R3";
    rx(8'h12, 1'b0); rx(8'h34, 1'b1);
    cur_req = "R4";
    sw_off(1'b0); rx(8'h56, 1'b0);

    cur_req = "R1";
    cfg_multidrop = 1'b1;
    rx(8'h09, 1'b1); rx(8'hA0, 1'b0);
    cur_req = "R7";
    sw_off(1'b1);
    rx(8'h0A, 1'b1); rx(8'hA1, 1'b0);
    sw_off(1'b0);
    rx(8'h0B, 1'b1);

    cur_req = "R5";
    cfg_auto_addr = 1'b1; cfg_station = 8'h5A;
    sw_off(1'b1);
    rx(8'h5A, 1'b1); rx(8'h10, 1'b0);
    cur_req = "R6";
    rx(8'h5B, 1'b1); rx(8'h11, 1'b0); rx(8'hDA, 1'b1); rx(8'h12, 1'b0);
    cur_req = "R5";
    rx(8'h5A, 1'b1); rx(8'h13, 1'b0);
    cfg_station = 8'h00;
    rx(8'h00, 1'b1); rx(8'h01, 1'b1); rx(8'h14, 1'b0);
    cfg_station = 8'hFF;
    rx(8'hFF, 1'b1); rx(8'h15, 1'b0); rx(8'hFE, 1'b1);

    cur_req = "R8";
    rx_data = 8'hFF; rx_bit9 = 1'b1; rx_valid = 1'b1; rxoff_we = 1'b1; rxoff_val = 1'b1;
    step();
    rx_valid = 1'b0; rxoff_we = 1'b0;
    step();
    rx_data = 8'h3C; rx_bit9 = 1'b1; rx_valid = 1'b1; rxoff_we = 1'b1; rxoff_val = 1'b0;
    step();
    rx_valid = 1'b0; rxoff_we = 1'b0; rx_bit9 = 1'b0;
    step();
    rx(8'h16, 1'b0);
    cfg_auto_addr = 1'b0; cfg_multidrop = 1'b0;
    sw_off(1'b0);

    cur_req = "R9";
    cfg_dir_en = 1'b1; cfg_dir_sel = 1'b0; dtr_modem = 1'b1;
    tx_active = 1'b1; step(3); tx_active = 1'b0; step(2);
    cfg_dir_inv = 1'b1; tx_active = 1'b1; step(2); tx_active = 1'b0; step(2);
    dtr_modem = 1'b0; step(2);

    cur_req = "R10";
    cfg_dir_sel = 1'b1; rts_modem = 1'b1;
    tx_active = 1'b1; step(2); tx_active = 1'b0; step(2);
    cfg_dir_inv = 1'b0; tx_active = 1'b1; step(2); rts_modem = 1'b0; step(1);
    tx_active = 1'b0; step(2);

    cur_req = "R11";
    cfg_dir_en = 1'b0;
    tx_active = 1'b1; rts_modem = 1'b1; step(2);
    dtr_modem = 1'b1; rts_modem = 1'b0; step(2);
    tx_active = 1'b0; dtr_modem = 1'b0; step(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule